// File: doc/BRIEF.md
# Auto-Run I2C Master Sequencer

This block is the transaction engine of an I2C controller. Software programs a target address, a byte count, a direction and a choice of whether to end with STOP, then sets a run bit once. From there the sequencer works through START, the address byte, the data phase and, optionally, STOP without further software help. Data passes through one-byte transmit and receive holding registers. When a holding register cannot serve the next byte, the bus simply waits.

Bit-level waveform generation is left to a separate timing generator. The sequencer hands that generator one command at a time (START, write byte, read byte, STOP) and waits for a completion pulse. On a write the generator returns the target's acknowledge bit, and on a read it returns the received byte. Results appear in a transaction-status register and in two interrupt-status bits that software clears by writing ones.

Top module: `i2c_auto_master`

## Requirements
- R1: After reset, every register reads zero, `bus_op` is 0 (none) and `irq` is low.
- R2: A write of 1 to bit 31 of the auto register (index 1) starts a transaction only if control bits 0 (I2C function) and 3 (master) are set and no transaction is running. Writes to the auto and address registers while busy are ignored. The auto register reads back as length in bits [LEN_W-1:0], direction in bit 16 (1 = read), stop flag in bit 17 and busy in bit 31.
- R3: A transaction first issues `bus_op`=1 (START), then `bus_op`=2 (write) carrying the address byte {field[6:0], direction}. The field sits in bits 19:10 of register index 2.
- R4: A write transaction sends exactly the programmed count of bytes from the transmit register (index 3) in order. `bus_op` stays 0 while that register is empty. A transmit write while it is full is ignored. Interrupt bit 0 is set at run and each time a byte is consumed.
- R5: A read transaction issues `bus_op`=3 once per programmed byte, with `bus_master_ack` 1 on every byte except the last. Each received byte lands in register index 4 and sets interrupt bit 9. No further read is issued until software has read that register.
- R6: If the address is not acknowledged, status bits 1 (abort), 2 (no ack) and 3 (no device) are set and the data phase is skipped.
- R7: If a written data byte is not acknowledged, status bits 1 and 2 are set and the remaining bytes are skipped.
- R8: `bus_op`=4 (STOP) is issued at the end only when the stop flag is set. A transaction without abort sets status bit 0 (done). Every end, with or without abort, sets interrupt bit 9.
- R9: Status bit 17 (busy) is 1 from the run edge until the transaction ends; `bus_op` is non-zero only while busy.
- R10: Writing ones to interrupt register index 5 clears those bits. A hardware set in the same cycle wins over the clear.
- R11: While control bit 31 is 1, the sequencer returns to idle and the status, interrupt and holding flags are cleared.
- R12: `irq` is high exactly when any interrupt-status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on receive register) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| bus_op | output | 3 | Command to timing generator: 0 none, 1 START, 2 write, 3 read, 4 STOP |
| bus_tx_byte | output | 8 | Byte to send with a write command |
| bus_master_ack | output | 1 | Acknowledge to give after a read byte |
| bus_done | input | 1 | Generator finished the current command |
| bus_rx_byte | input | 8 | Byte received, valid with `bus_done` on a read |
| bus_ack | input | 1 | Target acknowledge, valid with `bus_done` on a write |

## Verification
A software clear of the interrupt-status register can land on the same clock edge as the hardware setting the event bit for a received byte. The bench's bus model issues the clearing write in exactly the cycle in which it completes the second read of a transfer. Bit 9 must still read as set afterwards; otherwise the wait for that byte times out. A transmit-register write can also meet the register while it is still full. The bench makes that write right after loading a byte, and the byte the bus model then observes shows whether the write was refused.

// File: rtl/i2c_auto_master.sv
module i2c_auto_master #(
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic [2:0]  bus_op,
  output logic [7:0]  bus_tx_byte,
  output logic        bus_master_ack,
  input  logic        bus_done,
  input  logic [7:0]  bus_rx_byte,
  input  logic        bus_ack
);
  localparam logic [2:0] A_CTRL = 3'd0, A_AUTO = 3'd1, A_TADDR = 3'd2, A_TX = 3'd3,
                         A_RX = 3'd4, A_INT = 3'd5, A_XST = 3'd6;
  localparam logic [2:0] OP_NONE = 3'd0, OP_START = 3'd1, OP_WRITE = 3'd2,
                         OP_READ = 3'd3, OP_STOP = 3'd4;
  localparam logic [31:0] CTRL_MASK = 32'h8000_00C9;

  typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR, S_DATA, S_STOP} st_t;

  st_t              state;
  logic [31:0]      ctrl_q;
  logic [LEN_W-1:0] len_q, cnt;
  logic             rw_q, stop_q;
  logic [9:0]       taddr_q;
  logic [7:0]       tx_q, rx_q;
  logic             tx_full, rx_full;
  logic             int_tx, int_ev;
  logic             st_done, st_abort, st_nack, st_nodev;

  logic busy, xfer, run_ok, addr_nack, data_nack, data_end, wrap, finish;

  assign busy      = (state != S_IDLE);
  assign xfer      = bus_done && (bus_op != OP_NONE);
  assign run_ok    = reg_wr && reg_addr == A_AUTO && reg_wdata[31] &&
                     ctrl_q[0] && ctrl_q[3] && !busy;
  assign addr_nack = state == S_ADDR && xfer && !bus_ack;
  assign data_nack = state == S_DATA && xfer && !rw_q && !bus_ack;
  assign data_end  = state == S_DATA && cnt == '0;
  assign wrap      = addr_nack || data_nack || data_end;
  assign finish    = (wrap && !stop_q) || (state == S_STOP && xfer);
  assign irq       = int_tx || int_ev;

  always_comb begin
    case (state)
      S_START: bus_op = OP_START;
      S_ADDR:  bus_op = OP_WRITE;
      S_DATA:  bus_op = (cnt == '0) ? OP_NONE :
                        rw_q ? (rx_full ? OP_NONE : OP_READ) :
                               (tx_full ? OP_WRITE : OP_NONE);
      S_STOP:  bus_op = OP_STOP;
      default: bus_op = OP_NONE;
    endcase
  end

  assign bus_tx_byte    = (state == S_ADDR) ? {taddr_q[6:0], rw_q} : tx_q;
  assign bus_master_ack = (cnt != LEN_W'(1));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_AUTO:  begin
        reg_rdata[LEN_W-1:0] = len_q;
        reg_rdata[16] = rw_q;
        reg_rdata[17] = stop_q;
        reg_rdata[31] = busy;
      end
      A_TADDR: reg_rdata[19:10] = taddr_q;
      A_TX:    reg_rdata[7:0] = tx_q;
      A_RX:    reg_rdata[7:0] = rx_q;
      A_INT:   begin
        reg_rdata[0] = int_tx;
        reg_rdata[9] = int_ev;
      end
      A_XST:   reg_rdata = {14'd0, busy, 13'd0, st_nodev, st_nack, st_abort, st_done};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ctrl_q <= '0; len_q <= '0; cnt <= '0; rw_q <= 1'b0; stop_q <= 1'b0;
      taddr_q <= '0; tx_q <= '0; rx_q <= '0; tx_full <= 1'b0; rx_full <= 1'b0;
      int_tx <= 1'b0; int_ev <= 1'b0;
      st_done <= 1'b0; st_abort <= 1'b0; st_nack <= 1'b0; st_nodev <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata & CTRL_MASK;
      if (ctrl_q[31]) begin
        state <= S_IDLE; cnt <= '0;
        tx_full <= 1'b0; rx_full <= 1'b0; int_tx <= 1'b0; int_ev <= 1'b0;
        st_done <= 1'b0; st_abort <= 1'b0; st_nack <= 1'b0; st_nodev <= 1'b0;
      end else begin
        if (reg_wr && reg_addr == A_INT) begin
          if (reg_wdata[0]) int_tx <= 1'b0;
          if (reg_wdata[9]) int_ev <= 1'b0;
        end
        if (reg_wr && reg_addr == A_TX && !tx_full) begin
          tx_q <= reg_wdata[7:0];
          tx_full <= 1'b1;
        end
        if (reg_rd && reg_addr == A_RX) rx_full <= 1'b0;
        if (reg_wr && reg_addr == A_TADDR && !busy) taddr_q <= reg_wdata[19:10];
        if (reg_wr && reg_addr == A_AUTO && !busy) begin
          len_q  <= reg_wdata[LEN_W-1:0];
          rw_q   <= reg_wdata[16];
          stop_q <= reg_wdata[17];
        end
        if (run_ok) begin
          state <= S_START;
          cnt <= reg_wdata[LEN_W-1:0];
          st_done <= 1'b0; st_abort <= 1'b0; st_nack <= 1'b0; st_nodev <= 1'b0;
          if (!reg_wdata[16]) int_tx <= 1'b1;
        end
        case (state)
          S_START: if (xfer) state <= S_ADDR;
          S_ADDR:  if (xfer && bus_ack) state <= S_DATA;
          S_DATA:  if (xfer) begin
            cnt <= cnt - LEN_W'(1);
            if (rw_q) begin
              rx_q <= bus_rx_byte;
              rx_full <= 1'b1;
              int_ev <= 1'b1;
            end else begin
              tx_full <= 1'b0;
              int_tx <= 1'b1;
            end
          end
          S_STOP:  if (xfer) state <= S_IDLE;
          default: ;
        endcase
        if (addr_nack || data_nack) begin
          st_abort <= 1'b1;
          st_nack <= 1'b1;
        end
        if (addr_nack) st_nodev <= 1'b1;
        if (wrap) state <= stop_q ? S_STOP : S_IDLE;
        if (finish) begin
          int_ev <= 1'b1;
          if (!st_abort && !addr_nack && !data_nack) st_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_auto_master_chk.sv
module i2c_auto_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       srst,
  input logic [2:0] bus_op,
  input logic       bus_done,
  input logic [7:0] bus_tx_byte,
  input logic       busy,
  input logic       rx_full,
  input logic       st_done,
  input logic       st_abort
);
  p_op_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op != 3'd0 && !bus_done && !srst) |=> bus_op == $past(bus_op));

  p_byte_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == 3'd2 && !bus_done && !srst) |=> $stable(bus_tx_byte));

  p_rx_land_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == 3'd3 && bus_done && !srst) |=> rx_full);

  p_excl_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_done, st_abort}));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> !busy);

  p_op_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op != 3'd0) |-> busy);
endmodule

bind i2c_auto_master i2c_auto_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .srst(ctrl_q[31]), .bus_op(bus_op), .bus_done(bus_done),
  .bus_tx_byte(bus_tx_byte), .busy(busy), .rx_full(rx_full),
  .st_done(st_done), .st_abort(st_abort)
);

// File: tb/tb_i2c_auto_master.sv
module tb_i2c_auto_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_wr = 1'b0, m_rd = 1'b0, eng_wr = 1'b0;
  logic [2:0]  m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq;
  logic [2:0]  bus_op;
  logic [7:0]  bus_tx_byte;
  logic        bus_master_ack;
  logic        bus_done = 1'b0;
  logic [7:0]  bus_rx_byte = '0;
  logic        bus_ack = 1'b0;

  int checks = 0, failures = 0;
  bit ended = 0;

  assign reg_wr    = m_wr | eng_wr;
  assign reg_rd    = m_rd;
  assign reg_addr  = eng_wr ? 3'd5 : m_addr;
  assign reg_wdata = eng_wr ? 32'h0000_0201 : m_wdata;

  i2c_auto_master dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .bus_op(bus_op),
    .bus_tx_byte(bus_tx_byte), .bus_master_ack(bus_master_ack), .bus_done(bus_done),
    .bus_rx_byte(bus_rx_byte), .bus_ack(bus_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [2:0] op;
    logic [7:0] b;
    logic       mack;
    logic       ack;
    logic [7:0] rx;
    logic       clr;
    string      rq;
  } item_t;
  item_t exp_q[$];

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic push(logic [2:0] op, logic [7:0] b, logic mack, logic ack,
                      logic [7:0] rx, logic clr, string rq);
    item_t it;
    it.op = op; it.b = b; it.mack = mack; it.ack = ack; it.rx = rx; it.clr = clr; it.rq = rq;
    exp_q.push_back(it);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    m_wr = 1'b1; m_addr = a; m_wdata = d;
    @(negedge clk);
    m_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    m_rd = 1'b1; m_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    m_rd = 1'b0;
  endtask

  task automatic wait_idle(string rq);
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(3'd6, v);
      if (!v[17]) return;
    end
    chk(rq, "busy never cleared", 32'h1, 32'h0);
  endtask

  task automatic wait_int(int bitn, string rq);
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(3'd5, v);
      if (v[bitn]) return;
    end
    chk(rq, "interrupt bit never set", 32'h0, 32'h1);
  endtask

  // Monitor and bus model: pops expected commands and answers them
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n && bus_op != 3'd0) begin
        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R3 unexpected bus command actual=%0d expected=none", bus_op);
          it.ack = 1'b1; it.rx = '0; it.clr = 1'b0;
        end else begin
          it = exp_q.pop_front();
          if (bus_op !== it.op) begin
            failures++;
            $display("FAIL %s bus_op actual=%0d expected=%0d", it.rq, bus_op, it.op);
          end else if (it.op == 3'd2 && bus_tx_byte !== it.b) begin
            failures++;
            $display("FAIL %s tx byte actual=%h expected=%h", it.rq, bus_tx_byte, it.b);
          end else if (it.op == 3'd3 && bus_master_ack !== it.mack) begin
            failures++;
            $display("FAIL %s master ack actual=%b expected=%b", it.rq, bus_master_ack, it.mack);
          end
        end
        bus_ack = it.ack; bus_rx_byte = it.rx; bus_done = 1'b1; eng_wr = it.clr;
        @(negedge clk);
        bus_done = 1'b0; eng_wr = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=idle");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1", "register after reset", v, 32'h0);
    end
    chk("R1", "bus_op after reset", {29'd0, bus_op}, 32'h0);
    chk("R1", "irq after reset", {31'd0, irq}, 32'h0);

    // R2 run refused while function/master not enabled
    wr(3'd1, 32'h8002_0001);
    repeat (6) @(negedge clk);
    rd(3'd6, v);
    chk("R2", "status after refused run", v, 32'h0);
    chk("R2", "bus_op after refused run", {29'd0, bus_op}, 32'h0);
    wr(3'd0, 32'h0000_0089);

    // Write of three bytes with STOP
    push(3'd1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R3");
    push(3'd2, 8'hB4, 1'b0, 1'b1, 8'h00, 1'b0, "R3");
    push(3'd2, 8'hA1, 1'b0, 1'b1, 8'h00, 1'b0, "R4");
    push(3'd2, 8'hB2, 1'b0, 1'b1, 8'h00, 1'b0, "R4");
    push(3'd2, 8'hC3, 1'b0, 1'b1, 8'h00, 1'b0, "R4");
    push(3'd4, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R8");
    wr(3'd2, 32'h5A << 10);
    wr(3'd1, 32'h8002_0003);
    rd(3'd6, v);
    chk("R9", "busy after run", v, 32'h0002_0000);
    rd(3'd5, v);
    chk("R4", "tx interrupt at run", v, 32'h1);
    wr(3'd5, 32'h1);
    repeat (20) @(negedge clk);
    chk("R4", "stall with empty transmit register", {29'd0, bus_op}, 32'h0);
    wr(3'd3, 32'hA1);
    wr(3'd3, 32'hFF);
    wait_int(0, "R4");
    wr(3'd5, 32'h1);
    wr(3'd3, 32'hB2);
    wait_int(0, "R4");
    wr(3'd5, 32'h1);
    wr(3'd3, 32'hC3);
    wait_idle("R9");
    rd(3'd6, v);
    chk("R8", "status after write", v, 32'h1);
    rd(3'd5, v);
    chk("R8", "interrupts after write", v, 32'h201);
    chk("R12", "irq with pending bits", {31'd0, irq}, 32'h1);
    wr(3'd5, 32'h201);
    rd(3'd5, v);
    chk("R10", "interrupts after clear", v, 32'h0);
    chk("R12", "irq after clear", {31'd0, irq}, 32'h0);

    // Read of three bytes; second completion collides with a clear
    push(3'd1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R3");
    push(3'd2, 8'h27, 1'b0, 1'b1, 8'h00, 1'b0, "R3");
    push(3'd3, 8'h00, 1'b1, 1'b1, 8'h11, 1'b0, "R5");
    push(3'd3, 8'h00, 1'b1, 1'b1, 8'h22, 1'b1, "R10");
    push(3'd3, 8'h00, 1'b0, 1'b1, 8'h33, 1'b0, "R5");
    push(3'd4, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R8");
    wr(3'd2, 32'h13 << 10);
    wr(3'd1, 32'h8003_0003);
    wait_int(9, "R5");
    repeat (8) @(negedge clk);
    chk("R5", "no read while receive register full", {29'd0, bus_op}, 32'h0);
    wr(3'd5, 32'h200);
    rd(3'd4, v);
    chk("R5", "first received byte", v, 32'h11);
    wait_int(9, "R10");
    wr(3'd5, 32'h200);
    rd(3'd4, v);
    chk("R5", "second received byte", v, 32'h22);
    wait_int(9, "R5");
    wr(3'd5, 32'h200);
    rd(3'd4, v);
    chk("R5", "third received byte", v, 32'h33);
    wait_idle("R9");
    rd(3'd6, v);
    chk("R8", "status after read", v, 32'h1);
    wr(3'd5, 32'h201);

    // R6 address NACK with STOP
    push(3'd1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R6");
    push(3'd2, 8'h50, 1'b0, 1'b0, 8'h00, 1'b0, "R6");
    push(3'd4, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R6");
    wr(3'd2, 32'h28 << 10);
    wr(3'd1, 32'h8002_0002);
    wait_idle("R6");
    rd(3'd6, v);
    chk("R6", "status after address NACK", v, 32'hE);
    rd(3'd5, v);
    chk("R8", "event on aborted end", v & 32'h200, 32'h200);
    wr(3'd5, 32'h201);

    // R8 address NACK without STOP on a read
    push(3'd1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R8");
    push(3'd2, 8'h51, 1'b0, 1'b0, 8'h00, 1'b0, "R6");
    wr(3'd1, 32'h8001_0001);
    wait_idle("R8");
    repeat (6) @(negedge clk);
    rd(3'd6, v);
    chk("R6", "status after read address NACK", v, 32'hE);
    chk("R8", "no STOP without stop flag", {29'd0, bus_op}, 32'h0);
    wr(3'd5, 32'h201);

    // R7 data NACK skips the rest
    push(3'd1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R7");
    push(3'd2, 8'h50, 1'b0, 1'b1, 8'h00, 1'b0, "R7");
    push(3'd2, 8'h10, 1'b0, 1'b0, 8'h00, 1'b0, "R7");
    push(3'd4, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R7");
    wr(3'd1, 32'h8002_0003);
    wr(3'd3, 32'h10);
    wait_idle("R7");
    repeat (6) @(negedge clk);
    rd(3'd6, v);
    chk("R7", "status after data NACK", v, 32'h6);
    wr(3'd5, 32'h201);

    // R8 success without STOP
    push(3'd1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R8");
    push(3'd2, 8'h50, 1'b0, 1'b1, 8'h00, 1'b0, "R8");
    push(3'd2, 8'h77, 1'b0, 1'b1, 8'h00, 1'b0, "R8");
    wr(3'd1, 32'h8000_0001);
    wr(3'd3, 32'h77);
    wait_idle("R8");
    repeat (6) @(negedge clk);
    rd(3'd6, v);
    chk("R8", "status after stopless write", v, 32'h1);
    wr(3'd5, 32'h201);

    // R2 run while busy is ignored
    push(3'd1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R2");
    push(3'd2, 8'h50, 1'b0, 1'b1, 8'h00, 1'b0, "R2");
    push(3'd2, 8'h3C, 1'b0, 1'b1, 8'h00, 1'b0, "R2");
    push(3'd4, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R2");
    wr(3'd1, 32'h8002_0001);
    repeat (20) @(negedge clk);
    wr(3'd1, 32'h8001_0005);
    rd(3'd1, v);
    chk("R2", "auto register unchanged while busy", v, 32'h8002_0001);
    wr(3'd3, 32'h3C);
    wait_idle("R2");
    rd(3'd6, v);
    chk("R2", "status after busy-run test", v, 32'h1);
    wr(3'd5, 32'h201);

    // R11 soft reset in the middle of a stalled write
    push(3'd1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R11");
    push(3'd2, 8'h50, 1'b0, 1'b1, 8'h00, 1'b0, "R11");
    wr(3'd1, 32'h8002_0002);
    repeat (20) @(negedge clk);
    wr(3'd0, 32'h8000_0089);
    @(negedge clk);
    rd(3'd6, v);
    chk("R11", "status during soft reset", v, 32'h0);
    rd(3'd5, v);
    chk("R11", "interrupts during soft reset", v, 32'h0);
    chk("R11", "bus_op during soft reset", {29'd0, bus_op}, 32'h0);
    wr(3'd0, 32'h0000_0089);

    // Zero-length write after soft reset: address then STOP
    push(3'd1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R8");
    push(3'd2, 8'h50, 1'b0, 1'b1, 8'h00, 1'b0, "R3");
    push(3'd4, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, "R8");
    wr(3'd1, 32'h8002_0000);
    wait_idle("R8");
    repeat (6) @(negedge clk);
    rd(3'd6, v);
    chk("R8", "status after zero-length write", v, 32'h1);
    chk("R3", "all expected commands seen", exp_q.size(), 32'h0);

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule